// File: doc/BRIEF.md
# Pointer-Banked Register Map

This block is a byte-wide register map seen through a 64-location address window that is split into two halves. Address bit 5 picks the half and bits 4:0 give the offset inside it. Each half has its own 8-bit bank pointer, at offset 1Fh of that half (absolute addresses 1Fh and 3Fh). The value held in the pointer decides which bank answers at offsets 00h to 1Eh of that half. The lower half serves channels 0 to 7 and the upper half serves channels 8 to 15.

Each channel owns a test bank of five level-adjust bytes. These bytes drive the pulse shaper directly through a flat output bus. The other four banks of each half (primary, secondary, individual-channel and error-test) are plain byte storage. Software first writes a pointer code to select a bank. All later window accesses in that half then go to the selected bank, until the pointer is written again.

Each half's pointer decodes into one bank state: `BANK_PRI`, `BANK_SEC`, `BANK_IND`, `BANK_BERT`, `BANK_TEST` or `BANK_NONE`. A write to the pointer moves the state:
- code 00h moves it to `BANK_PRI`;
- code AAh moves it to `BANK_SEC`;
- code 01h moves it to `BANK_IND`;
- code 02h moves it to `BANK_BERT`;
- codes 04h to 0Bh move it to `BANK_TEST` for channel (code - 4) of that half;
- any other code moves it to `BANK_NONE`.

Reset enters `BANK_PRI`.

Top module: `banked_regs`

## Requirements
- R1: While reset is asserted, both pointers hold 00h, every level-adjust byte holds 00h and the read data output is 00h.
- R2: Offset 1Fh of each half always reads and writes that half's pointer, whatever bank is selected. The pointer keeps any 8-bit value written to it and reads back exactly that value.
- R3: With lower-half pointer code 04h+k (k = 0..7), a write at offsets 00h to 04h stores into level byte 0 to 4 of channel k. Level byte r of channel c appears at `lvl_q[(c*5+r)*8 +: 8]` and reads back at the same offset. The bus changes only when such a write occurs.
- R4: The upper-half pointer, with code 04h+k, selects channel 8+k in the same way. Each pointer changes only when its own offset-1Fh location is written.
- R5: Pointer codes 00h, AAh, 01h and 02h each select a separate plain storage bank of 8 bytes per half, at offsets 00h to 07h. A byte written in one bank is not visible in another.
- R6: A pointer code outside 00h, 01h, 02h, AAh and 04h to 0Bh (for example 03h or FFh) selects no bank. Window reads then return 00h and window writes change nothing.
- R7: Offsets that fall outside the selected bank read 00h and ignore writes. These are offsets 05h to 1Eh of a test bank and offsets 08h to 1Eh of a plain bank.
- R8: A read strobe with address A in one clock cycle puts the value of A on `rdata` after that clock edge. `rdata` holds its value in every cycle without a read strobe.
- R9: When a read and a write to the same location happen in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | Bit 5 selects the half, bits 4:0 the offset; 1Fh is the pointer |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; data is returned after the next clock edge |
| rdata | output | 8 | Registered read data |
| lvl_q | output | 640 | Level-adjust bytes of 16 channels x 5 registers, byte (c*5+r) |

## Verification
A wrong pointer value or a wrong bank decode shows up one cycle after the next read. The read returns data from the wrong bank, or from an offset that should be dead, or a zero where stored data is expected. A wrong channel index shows up at once on the level bus after a single write, because the byte lands in the wrong slice. The bench therefore follows every write to a test bank with a direct check of the level bus. It crosses bank switches with read-backs, so that a leak between banks shows up in the first read after the switch.

// File: rtl/banked_regs_pkg.sv
package banked_regs_pkg;

    typedef enum logic [2:0] {
        BANK_PRI  = 3'd0,
        BANK_SEC  = 3'd1,
        BANK_IND  = 3'd2,
        BANK_BERT = 3'd3,
        BANK_TEST = 3'd4,
        BANK_NONE = 3'd5
    } bank_e;

    localparam logic [7:0] PTR_PRI   = 8'h00;
    localparam logic [7:0] PTR_SEC   = 8'hAA;
    localparam logic [7:0] PTR_IND   = 8'h01;
    localparam logic [7:0] PTR_BERT  = 8'h02;
    localparam logic [7:0] PTR_TEST0 = 8'h04;

    localparam logic [4:0] OFF_PTR   = 5'h1F;

endpackage

// File: rtl/banked_regs_ptr.sv
module banked_regs_ptr
    import banked_regs_pkg::*;
#(
    parameter int CH_PER_HALF = 8,
    localparam int CH_W = (CH_PER_HALF > 1) ? $clog2(CH_PER_HALF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ptr_we,
    input  logic [7:0]      wdata,
    output logic [7:0]      ptr_q,
    output bank_e           bank,
    output logic [CH_W-1:0] chan
);

    // pointer register: the bank state of this half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= PTR_PRI;
        end else if (ptr_we) begin
            ptr_q <= wdata;
        end
    end

    // decode of the pointer code into a bank state
    always_comb begin
        bank = BANK_NONE;
        chan = '0;
        if (ptr_q >= PTR_TEST0 && ptr_q < PTR_TEST0 + 8'(CH_PER_HALF)) begin
            bank = BANK_TEST;
            chan = CH_W'(ptr_q - PTR_TEST0);
        end else begin
            unique case (ptr_q)
                PTR_PRI:  bank = BANK_PRI;
                PTR_SEC:  bank = BANK_SEC;
                PTR_IND:  bank = BANK_IND;
                PTR_BERT: bank = BANK_BERT;
                default:  bank = BANK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/banked_regs_lvl.sv
module banked_regs_lvl #(
    parameter int LVL_REGS = 5,
    localparam int RW = (LVL_REGS > 1) ? $clog2(LVL_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [RW-1:0]         wsel,
    input  logic [7:0]            wdata,
    output logic [LVL_REGS*8-1:0] lvl
);

    for (genvar r = 0; r < LVL_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl[r*8 +: 8] <= 8'h00;
            end else if (we && wsel == RW'(r)) begin
                lvl[r*8 +: 8] <= wdata;
            end
        end
    end

endmodule

// File: rtl/banked_regs_plain.sv
module banked_regs_plain #(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    bsel,
    input  logic [PW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [4][DEPTH];

    for (genvar b = 0; b < 4; b++) begin : g_bank
        for (genvar i = 0; i < DEPTH; i++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[b][i] <= 8'h00;
                end else if (we && bsel == 2'(b) && idx == PW'(i)) begin
                    mem[b][i] <= wdata;
                end
            end
        end
    end

    assign rdata = mem[bsel][idx];

endmodule

// File: rtl/banked_regs.sv
module banked_regs
    import banked_regs_pkg::*;
#(
    parameter int CH_PER_HALF = 8,
    parameter int LVL_REGS    = 5,
    parameter int PLAIN_DEPTH = 8,
    localparam int N_CH  = 2 * CH_PER_HALF,
    localparam int CH_W  = (CH_PER_HALF > 1) ? $clog2(CH_PER_HALF) : 1,
    localparam int NCH_W = $clog2(N_CH),
    localparam int RW    = (LVL_REGS > 1) ? $clog2(LVL_REGS) : 1,
    localparam int PW    = (PLAIN_DEPTH > 1) ? $clog2(PLAIN_DEPTH) : 1,
    localparam int LVL_W = N_CH * LVL_REGS * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [7:0]       rdata,
    output logic [LVL_W-1:0] lvl_q
);

    logic            half;
    logic [4:0]      off;
    logic            is_ptr;
    logic            win_wr;
    logic [7:0]      ptr_q    [2];
    bank_e           bank_h   [2];
    logic [CH_W-1:0] chan_h   [2];
    logic [7:0]      plain_rd [2];
    bank_e           sel_bank;
    logic [NCH_W-1:0] abs_ch;
    logic            is_plain;
    logic [1:0]      plain_idx;
    logic [7:0]      rd_next;

    assign half     = addr[5];
    assign off      = addr[4:0];
    assign is_ptr   = (off == OFF_PTR);
    assign win_wr   = wr_en && !is_ptr;
    assign sel_bank = bank_h[half];
    assign abs_ch   = NCH_W'(half) * NCH_W'(CH_PER_HALF) + NCH_W'(chan_h[half]);

    // plain bank index from the selected bank state
    always_comb begin
        is_plain  = 1'b1;
        plain_idx = 2'd0;
        unique case (sel_bank)
            BANK_PRI:  plain_idx = 2'd0;
            BANK_SEC:  plain_idx = 2'd1;
            BANK_IND:  plain_idx = 2'd2;
            BANK_BERT: plain_idx = 2'd3;
            default:   is_plain  = 1'b0;
        endcase
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        banked_regs_ptr #(
            .CH_PER_HALF(CH_PER_HALF)
        ) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .ptr_we(wr_en && is_ptr && (half == 1'(h))),
            .wdata (wdata),
            .ptr_q (ptr_q[h]),
            .bank  (bank_h[h]),
            .chan  (chan_h[h])
        );

        banked_regs_plain #(
            .DEPTH(PLAIN_DEPTH)
        ) u_plain (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (win_wr && is_plain && (half == 1'(h)) && (off < 5'(PLAIN_DEPTH))),
            .bsel (plain_idx),
            .idx  (off[PW-1:0]),
            .wdata(wdata),
            .rdata(plain_rd[h])
        );
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        banked_regs_lvl #(
            .LVL_REGS(LVL_REGS)
        ) u_lvl (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (win_wr && (sel_bank == BANK_TEST) && (abs_ch == NCH_W'(c))
                   && (off < 5'(LVL_REGS))),
            .wsel (off[RW-1:0]),
            .wdata(wdata),
            .lvl  (lvl_q[c*LVL_REGS*8 +: LVL_REGS*8])
        );
    end

    // read selection by bank state
    always_comb begin
        rd_next = 8'h00;
        if (is_ptr) begin
            rd_next = ptr_q[half];
        end else begin
            unique case (sel_bank)
                BANK_PRI, BANK_SEC, BANK_IND, BANK_BERT: begin
                    if (off < 5'(PLAIN_DEPTH)) rd_next = plain_rd[half];
                end
                BANK_TEST: begin
                    if (off < 5'(LVL_REGS))
                        rd_next = lvl_q[(int'(abs_ch) * LVL_REGS + int'(off)) * 8 +: 8];
                end
                default: rd_next = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/banked_regs_chk.sv
module banked_regs_chk #(
    parameter int CH_PER_HALF = 8,
    parameter int LVL_REGS    = 5,
    parameter int LVL_W       = 640
) (
    input logic             clk,
    input logic             rst_n,
    input logic [5:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       rdata,
    input logic [LVL_W-1:0] lvl_q,
    input logic [7:0]       ptr_lo,
    input logic [7:0]       ptr_hi
);

    logic [7:0] cur_ptr;
    logic       win_acc;
    logic       cur_test;
    logic       cur_reserved;

    assign cur_ptr  = addr[5] ? ptr_hi : ptr_lo;
    assign win_acc  = (addr[4:0] != 5'h1F);
    assign cur_test = (cur_ptr >= 8'h04) && (cur_ptr < 8'h04 + 8'(CH_PER_HALF));
    assign cur_reserved = !cur_test && (cur_ptr != 8'h00) && (cur_ptr != 8'h01)
                          && (cur_ptr != 8'h02) && (cur_ptr != 8'hAA);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rdata == 8'h00 && lvl_q == '0 && ptr_lo == 8'h00 && ptr_hi == 8'h00));

    assert_ptr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !win_acc) |=> (rdata == $past(cur_ptr)));

    assert_lvl_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lvl_q));

    assert_ptr_indep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 6'h1F) |=> $stable(ptr_lo));

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win_acc && cur_reserved) |=> (rdata == 8'h00));

    assert_test_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win_acc && cur_test && addr[4:0] >= 5'(LVL_REGS)) |=> (rdata == 8'h00));

    assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind banked_regs banked_regs_chk #(
    .CH_PER_HALF(CH_PER_HALF),
    .LVL_REGS   (LVL_REGS),
    .LVL_W      (LVL_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .lvl_q (lvl_q),
    .ptr_lo(ptr_q[0]),
    .ptr_hi(ptr_q[1])
);

// File: tb/banked_regs_bench.sv
module banked_regs_bench;

    localparam int LVL_W = 640;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       addr = '0;
    logic [7:0]       wdata = '0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       rdata;
    logic [LVL_W-1:0] lvl_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    banked_regs u_banked_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wdata(wdata),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .rdata(rdata),
        .lvl_q(lvl_q)
    );

    always #5 clk = ~clk;

    task automatic expect8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] get_lvl(input int c, input int r);
        return lvl_q[(c * 5 + r) * 8 +: 8];
    endfunction

    // driver: one bus cycle, pushes the expected read result
    task automatic acc(input logic [5:0] a, input logic [7:0] d, input logic we,
                       input logic re, input logic [7:0] exp, input string tag);
        addr  = a;
        wdata = d;
        wr_en = we;
        rd_en = re;
        if (re) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        acc(a, d, 1'b1, 1'b0, 8'h00, "");
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
        acc(a, 8'h00, 1'b0, 1'b1, exp, tag);
    endtask

    // monitor
    always @(posedge clk) rd_seen <= rd_en && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 actual=%02h expected=none (unexpected read)", rdata);
            end else begin
                expect8(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect8(rdata, 8'h00, "R1 rdata in reset");
        checks++;
        if (lvl_q !== '0) begin
            errors++;
            $display("FAIL R1 actual=nonzero expected=all zero level bus");
        end
        rst_n = 1'b1;
        @(negedge clk);
        rd(6'h1F, 8'h00, "R1 lower pointer reset");
        rd(6'h3F, 8'h00, "R1 upper pointer reset");

        // plain banks R5
        wr(6'h02, 8'h11);
        rd(6'h02, 8'h11, "R5 primary readback");
        wr(6'h1F, 8'hAA);
        rd(6'h02, 8'h00, "R5 secondary separate");
        wr(6'h02, 8'h22);
        rd(6'h02, 8'h22, "R5 secondary readback");
        wr(6'h1F, 8'h01);
        wr(6'h00, 8'h33);
        rd(6'h00, 8'h33, "R5 individual readback");
        wr(6'h1F, 8'h02);
        wr(6'h07, 8'h44);
        rd(6'h07, 8'h44, "R5 error-test bank top byte");
        wr(6'h1F, 8'h00);
        rd(6'h02, 8'h11, "R5 primary kept");
        rd(6'h00, 8'h00, "R5 primary untouched by individual");
        rd(6'h09, 8'h00, "R7 plain offset beyond depth");
        rd(6'h1F, 8'h00, "R2 pointer readback");

        // test bank of channel 1 R3
        wr(6'h1F, 8'h05);
        for (int r = 0; r < 5; r++) wr(6'(r), 8'hA0 + 8'(r));
        for (int r = 0; r < 5; r++) expect8(get_lvl(1, r), 8'hA0 + 8'(r), "R3 channel 1 level byte");
        expect8(get_lvl(0, 0), 8'h00, "R3 channel 0 untouched");
        rd(6'h03, 8'hA3, "R3 level readback");
        rd(6'h1F, 8'h05, "R2 pointer with test bank");
        wr(6'h05, 8'h55);
        rd(6'h05, 8'h00, "R7 test offset 05");
        rd(6'h1E, 8'h00, "R7 test offset 1E");
        expect8(get_lvl(2, 0), 8'h00, "R7 gap write did not spill");
        wr(6'h1F, 8'h0B);
        wr(6'h00, 8'h77);
        expect8(get_lvl(7, 0), 8'h77, "R3 channel 7 byte 0");

        // upper half R4
        wr(6'h3F, 8'h04);
        wr(6'h22, 8'hC2);
        expect8(get_lvl(8, 2), 8'hC2, "R4 channel 8 byte 2");
        expect8(get_lvl(0, 2), 8'h00, "R4 channel 0 byte 2 untouched");
        rd(6'h1F, 8'h0B, "R4 lower pointer unchanged");
        rd(6'h3F, 8'h04, "R4 upper pointer");
        rd(6'h22, 8'hC2, "R4 upper readback");
        wr(6'h3F, 8'h0B);
        wr(6'h24, 8'hFE);
        expect8(get_lvl(15, 4), 8'hFE, "R4 channel 15 byte 4");

        // reserved codes R6
        wr(6'h1F, 8'h03);
        wr(6'h00, 8'h99);
        rd(6'h00, 8'h00, "R6 reserved code 03 reads zero");
        expect8(get_lvl(0, 0), 8'h00, "R6 reserved write ignored (level)");
        wr(6'h1F, 8'hFF);
        rd(6'h1F, 8'hFF, "R2 pointer holds FF");
        wr(6'h01, 8'h98);
        rd(6'h01, 8'h00, "R6 reserved code FF reads zero");
        wr(6'h1F, 8'h00);
        rd(6'h00, 8'h00, "R6 reserved write ignored (primary)");
        rd(6'h01, 8'h00, "R6 reserved write ignored (primary 01)");

        // simultaneous read and write R9
        acc(6'h02, 8'h5A, 1'b1, 1'b1, 8'h11, "R9 read returns old value");
        rd(6'h02, 8'h5A, "R9 new value after write");

        // hold R8
        wr(6'h03, 8'h66);
        repeat (3) @(negedge clk);
        expect8(rdata, 8'h5A, "R8 rdata held without read");
        rd(6'h03, 8'h66, "R8 next read updates");

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 actual=%0d expected=0 pending reads", exp_q.size());
        end
        finish_run();
    end

endmodule